// File: doc/BRIEF.md
# NOR flash bus front end

This block is the device-side pin logic of a parallel NOR flash. It samples the active-low chip enable, output enable, write enable and address-valid pins, plus the flash clock, on an internal system clock. From them it classifies each cycle as one of eight bus operations. It captures a 23-bit word address and keeps a burst address counter. It decides whether the 16-bit data bus is driven, and it produces a WAIT indication.

The data bus and WAIT are modelled as separate data and output-enable pairs, so that a pad ring can build the tristate buffers. The device reset pin `rst_ni` is also the block reset. Commands written on the bus do the following:
- They switch each 256K-word partition between array reads and identifier reads.
- They select asynchronous-page or synchronous-burst reads.
- They select which edge of the flash clock is active.

Read data comes from one of two sources. The first is a behavioural array, whose contents are computed from the address. The second is a pair of identifier words found at the base of each partition.

Top module: `nor_bus_front`

## Requirements
- R1: While `rst_ni` is low, `dq_oe_o` and `wait_oe_o` are 0 and `op_o` is 0 (reset), whatever the other pins do. Reset returns the block to asynchronous mode with rising clock edge, and puts every partition in array mode.
- R2: While `ce_ni` is high and reset is inactive, `op_o` is 1 (standby) and `dq_oe_o` and `wait_oe_o` are 0.
- R3: With `ce_ni` low, the data bus direction follows the enable pins:
  - `oe_ni` low with `we_ni` high drives the bus, and `op_o` is 2 (asynchronous read) or 3 (synchronous read).
  - `we_ni` low with `oe_ni` high gives `op_o`=5 (write) and leaves the bus undriven.
  - Both high gives `op_o`=6 (output disable) in asynchronous mode, with the bus undriven and `wait_oe_o` and `wait_o` at 1.
- R4: With `ce_ni`, `oe_ni` and `we_ni` all low, `illegal_o` is 1, `op_o` is 7 and `dq_oe_o` is 0.
- R5: In asynchronous mode the read address follows `addr_i` while `adv_ni` is low. On the rising edge of `adv_ni` the address is held, and later changes of `addr_i` are ignored. An array word at address A reads as `A[15:0] ^ {9'b0, A[22:16]}`.
- R6: In asynchronous mode, toggling `fclk_i` leaves the read data unchanged.
- R7: In synchronous mode, the first active flash-clock edge while `adv_ni` is low loads `addr_i` into the burst counter. Address changes after that edge are ignored.
- R8: In synchronous mode, if `adv_ni` rises before any active clock edge, the burst counter loads the last address that was present while `adv_ni` was low.
- R9: After capture, each active flash-clock edge with `adv_ni` high and `ce_ni` low adds one to the burst counter, and the next word is presented. With falling-edge mode selected, only falling edges of `fclk_i` count.
- R10: While `fclk_i` is halted in synchronous mode, the counter holds. With `oe_ni` and `we_ni` high, `op_o` is 4 (burst suspend) and the bus is undriven. Lowering `oe_ni` again presents the same word, and the burst resumes from it.
- R11: During synchronous array reads, `wait_o` is 1 for exactly one flash-clock period after the counter lands on an address whose low 4 bits are zero, and 0 otherwise. In every other chip-enabled state, `wait_o` is 1.
- R12: A write of data 0x0090 puts the addressed partition (address bits 22:18) in identifier mode, and a write of 0x00FF returns it to array mode. Other partitions are not affected. In identifier mode, offset 0 reads 0x00B7, offset 1 reads 0x88C1, and every other offset reads 0x0000.
- R13: A write of data 0x0060 sets the read mode from address bit 1 (1 = synchronous) and the active clock edge from address bit 0 (1 = falling).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal system clock used to sample the pins |
| rst_ni | input | 1 | Device reset pin, active low, asynchronous |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| adv_ni | input | 1 | Address valid, active low |
| fclk_i | input | 1 | Flash bus clock used for bursts |
| addr_i | input | 23 | Word address |
| dq_i | input | 16 | Data bus input value |
| dq_o | output | 16 | Data bus output value |
| dq_oe_o | output | 1 | Data bus output enable |
| wait_o | output | 1 | WAIT value |
| wait_oe_o | output | 1 | WAIT output enable |
| op_o | output | 3 | Decoded bus operation |
| illegal_o | output | 1 | Output and write enables both low |

## Verification
The hardest states to reach are those that depend on how events are ordered on slow pins relative to the system clock. These are the race between a rising address-valid edge and the first active flash-clock edge, a burst held with its clock stopped, and the single-period WAIT pulse at a 16-word boundary. The bench produces the flash clock as a slow signal of its own, moved only between system clock edges, so the order of these events is chosen exactly. It starts bursts just below a boundary, so that two edges reach the crossing. It also stops the clock in the middle of a burst and lowers the output enable again before restarting it.

// File: rtl/nor_bus_pkg.sv
package nor_bus_pkg;
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_ARD     = 3'd2,
    OP_SRD     = 3'd3,
    OP_SUSP    = 3'd4,
    OP_WRITE   = 3'd5,
    OP_ODIS    = 3'd6,
    OP_ILLEGAL = 3'd7
  } bus_op_e;

  localparam logic [15:0] CMD_ARRAY  = 16'h00FF;
  localparam logic [15:0] CMD_IDENT  = 16'h0090;
  localparam logic [15:0] CMD_CONFIG = 16'h0060;
endpackage

// File: rtl/nor_bus_decode.sv
module nor_bus_decode
  import nor_bus_pkg::*;
(
  input  logic    rst_ni,
  input  logic    ce_ni,
  input  logic    oe_ni,
  input  logic    we_ni,
  input  logic    sync_i,
  output bus_op_e op_o
);
  always_comb begin
    if (!rst_ni)               op_o = OP_RESET;
    else if (ce_ni)            op_o = OP_STANDBY;
    else if (!oe_ni && !we_ni) op_o = OP_ILLEGAL;
    else if (!we_ni)           op_o = OP_WRITE;
    else if (!oe_ni)           op_o = sync_i ? OP_SRD : OP_ARD;
    else                       op_o = sync_i ? OP_SUSP : OP_ODIS;
  end
endmodule

// File: rtl/nor_bus_addr.sv
module nor_bus_addr #(
  parameter int AW        = 23,
  parameter int ROW_WORDS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          fall_i,
  input  logic          ce_ni,
  input  logic          adv_ni,
  input  logic          fclk_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] lat_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW-1:0] cnt_o,
  output logic          row_wait_o,
  output logic          fedge_o,
  output logic          adv_rise_o
);
  localparam int RW = $clog2(ROW_WORDS);

  logic          fclk_q, adv_q, cap_done_q, wait_q;
  logic [AW-1:0] addr_q, cnt_q, cnt_nxt;
  logic          adv_fall;

  assign fedge_o    = fall_i ? (fclk_q & ~fclk_i) : (~fclk_q & fclk_i);
  assign adv_rise_o = ~adv_q & adv_ni;
  assign adv_fall   = adv_q & ~adv_ni;
  assign cnt_nxt    = cnt_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q     <= 1'b0;
      adv_q      <= 1'b1;
      cap_done_q <= 1'b0;
      wait_q     <= 1'b0;
      addr_q     <= '0;
      cnt_q      <= '0;
    end else begin
      fclk_q <= fclk_i;
      adv_q  <= adv_ni;
      if (!adv_ni) addr_q <= addr_i;
      if (sync_i && !ce_ni) begin
        if (!adv_ni) begin
          // first clock edge in an address phase captures
          if (fedge_o && (adv_fall || !cap_done_q)) begin
            cnt_q      <= addr_i;
            cap_done_q <= 1'b1;
            wait_q     <= 1'b0;
          end else if (adv_fall) begin
            cap_done_q <= 1'b0;
          end
        end else if (adv_rise_o && !cap_done_q) begin
          cnt_q      <= addr_q;
          cap_done_q <= 1'b1;
          wait_q     <= 1'b0;
        end else if (fedge_o && cap_done_q) begin
          cnt_q  <= cnt_nxt;
          wait_q <= (cnt_nxt[RW-1:0] == '0);
        end
      end
    end
  end

  assign lat_addr_o = adv_ni ? addr_q : addr_i;
  assign rd_addr_o  = sync_i ? cnt_q : lat_addr_o;
  assign cnt_o      = cnt_q;
  assign row_wait_o = wait_q;
endmodule

// File: rtl/nor_bus_rdmux.sv
module nor_bus_rdmux
  import nor_bus_pkg::*;
#(
  parameter int          AW     = 23,
  parameter int          DW     = 16,
  parameter int          PAW    = 18,
  parameter logic [15:0] ID_MFR = 16'h00B7,
  parameter logic [15:0] ID_DEV = 16'h88C1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_ident_o,
  output logic          sync_o,
  output logic          fall_o
);
  localparam int PW    = AW - PAW;
  localparam int NPART = 1 << PW;

  logic          id_mode [NPART];
  logic [PW-1:0] wr_part, rd_part;
  logic [PAW-1:0] rd_off;
  logic [15:0]   cmd;

  assign wr_part = wr_addr_i[AW-1:PAW];
  assign rd_part = rd_addr_i[AW-1:PAW];
  assign rd_off  = rd_addr_i[PAW-1:0];
  assign cmd     = 16'(wr_data_i);

  for (genvar p = 0; p < NPART; p++) begin : g_part
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) id_mode[p] <= 1'b0;
      else if (wr_stb_i && wr_part == PW'(p)) begin
        if (cmd == CMD_IDENT)      id_mode[p] <= 1'b1;
        else if (cmd == CMD_ARRAY) id_mode[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_o <= 1'b0;
      fall_o <= 1'b0;
    end else if (wr_stb_i && cmd == CMD_CONFIG) begin
      sync_o <= wr_addr_i[1];
      fall_o <= wr_addr_i[0];
    end
  end

  assign rd_ident_o = id_mode[rd_part];

  always_comb begin
    if (!rd_ident_o)       rd_data_o = rd_addr_i[DW-1:0] ^ DW'(rd_addr_i >> DW);
    else if (rd_off == '0) rd_data_o = DW'(ID_MFR);
    else if (rd_off == PAW'(1)) rd_data_o = DW'(ID_DEV);
    else                   rd_data_o = '0;
  end
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
  import nor_bus_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int PAW       = 18,
  parameter int ROW_WORDS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          adv_ni,
  input  logic          fclk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          wait_o,
  output logic          wait_oe_o,
  output logic [2:0]    op_o,
  output logic          illegal_o
);
  bus_op_e       op;
  logic          sync_mode, fall_mode, rd_ident, row_wait, fclk_edge, adv_rise;
  logic          we_q, wr_stb, drive;
  logic [AW-1:0] lat_addr, rd_addr, burst_cnt;
  logic [DW-1:0] rd_data;

  nor_bus_decode u_dec (
    .rst_ni (rst_ni), .ce_ni (ce_ni), .oe_ni (oe_ni), .we_ni (we_ni),
    .sync_i (sync_mode), .op_o (op)
  );

  nor_bus_addr #(.AW(AW), .ROW_WORDS(ROW_WORDS)) u_addr (
    .clk_i      (clk_i),     .rst_ni     (rst_ni),
    .sync_i     (sync_mode), .fall_i     (fall_mode),
    .ce_ni      (ce_ni),     .adv_ni     (adv_ni),
    .fclk_i     (fclk_i),    .addr_i     (addr_i),
    .lat_addr_o (lat_addr),  .rd_addr_o  (rd_addr),
    .cnt_o      (burst_cnt), .row_wait_o (row_wait),
    .fedge_o    (fclk_edge), .adv_rise_o (adv_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  // command taken on the falling edge of a legal write strobe
  assign wr_stb = !ce_ni && we_q && !we_ni && oe_ni;

  nor_bus_rdmux #(.AW(AW), .DW(DW), .PAW(PAW)) u_rd (
    .clk_i      (clk_i),    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb),   .wr_addr_i  (lat_addr),
    .wr_data_i  (dq_i),     .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),  .rd_ident_o (rd_ident),
    .sync_o     (sync_mode), .fall_o    (fall_mode)
  );

  assign drive     = (op == OP_ARD) || (op == OP_SRD);
  assign dq_oe_o   = drive;
  assign dq_o      = drive ? rd_data : '0;
  assign wait_oe_o = rst_ni && !ce_ni;
  assign wait_o    = !wait_oe_o ? 1'b0 :
                     (sync_mode && !rd_ident && we_ni) ? row_wait : 1'b1;
  assign op_o      = op;
  assign illegal_o = (op == OP_ILLEGAL);
endmodule

// File: rtl/nor_bus_front_chk.sv
module nor_bus_front_chk #(
  parameter int AW = 23
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          we_ni,
  input logic          adv_ni,
  input logic          dq_oe_o,
  input logic          wait_o,
  input logic          wait_oe_o,
  input logic          illegal_o,
  input logic          sync_mode,
  input logic          fclk_edge,
  input logic          adv_rise,
  input logic [AW-1:0] burst_cnt
);
  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_HIZ: assert (!dq_oe_o && !wait_oe_o); // R1
    if (rst_ni && ce_ni) AST_STANDBY_HIZ: assert (!dq_oe_o && !wait_oe_o); // R2
  end

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |-> !dq_oe_o); // R3

  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !we_ni) |-> illegal_o); // R4

  AST_ILLEGAL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !dq_oe_o); // R4

  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_ni && !adv_rise && !fclk_edge) |=> $stable(burst_cnt)); // R10

  AST_ASYNC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !sync_mode) |-> (wait_o && wait_oe_o)); // R11
endmodule

bind nor_bus_front nor_bus_front_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),     .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),     .oe_ni     (oe_ni),
  .we_ni     (we_ni),     .adv_ni    (adv_ni),
  .dq_oe_o   (dq_oe_o),   .wait_o    (wait_o),
  .wait_oe_o (wait_oe_o), .illegal_o (illegal_o),
  .sync_mode (sync_mode), .fclk_edge (fclk_edge),
  .adv_rise  (adv_rise),  .burst_cnt (burst_cnt)
);

// File: tb/nor_bus_front_test.sv
`timescale 1ns/1ps
module nor_bus_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1, fclk = 1'b0;
  logic [22:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe, wt, wt_oe, illegal;
  logic [2:0]  op;
  int          n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  nor_bus_front uut (
    .clk_i (clk), .rst_ni (rst_n), .ce_ni (ce_n), .oe_ni (oe_n), .we_ni (we_n),
    .adv_ni (adv_n), .fclk_i (fclk), .addr_i (addr), .dq_i (dq_in),
    .dq_o (dq_out), .dq_oe_o (dq_oe), .wait_o (wt), .wait_oe_o (wt_oe),
    .op_o (op), .illegal_o (illegal)
  );

  function automatic logic [15:0] arr(input logic [22:0] a);
    return a[15:0] ^ {9'b0, a[22:16]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [22:0] a, input logic [15:0] d);
    ce_n = 0; oe_n = 1; adv_n = 0; addr = a; dq_in = d; we_n = 0;
    step(1);
    chk("R3 write op", op, 5);
    chk("R3 write undriven", dq_oe, 0);
    we_n = 1;
    step(1);
  endtask

  task automatic fedge_pulse(input logic lvl);
    fclk = lvl;
    step(1);
  endtask

  task automatic t_reset();
    ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); rst_n = 0; #1;
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 wait_oe", wt_oe, 0);
    chk("R1 op", op, 0);
    step(2);
    rst_n = 1; ce_n = 1; oe_n = 1;
    step(1);
  endtask

  task automatic t_standby_dir();
    ce_n = 1; oe_n = 0; step(1);
    chk("R2 op", op, 1);
    chk("R2 dq_oe", dq_oe, 0);
    chk("R2 wait_oe", wt_oe, 0);
    ce_n = 0; oe_n = 1; we_n = 1; step(1);
    chk("R3 odis op", op, 6);
    chk("R3 odis dq_oe", dq_oe, 0);
    chk("R3 odis wait", {wt_oe, wt}, 2'b11);
    oe_n = 0; we_n = 0; step(1);
    chk("R4 illegal", illegal, 1);
    chk("R4 op", op, 7);
    chk("R4 no drive", dq_oe, 0);
    we_n = 1; step(1);
    chk("R4 clear", illegal, 0);
  endtask

  task automatic t_async();
    ce_n = 0; oe_n = 0; we_n = 1; adv_n = 0; addr = 23'h1A_5C3E; step(1);
    chk("R3 async read op", op, 2);
    chk("R5 transparent", dq_out, arr(23'h1A_5C3E));
    chk("R11 async wait", {wt_oe, wt}, 2'b11);
    addr = 23'h02_1234; step(1);
    chk("R5 follows addr", dq_out, arr(23'h02_1234));
    adv_n = 1; addr = 23'h7F_0001; step(1);
    chk("R5 latched on adv rise", dq_out, arr(23'h02_1234));
    fedge_pulse(1); fedge_pulse(0); fedge_pulse(1); fedge_pulse(0);
    chk("R6 clock ignored", dq_out, arr(23'h02_1234));
    oe_n = 1; step(1);
  endtask

  task automatic t_sync_clk();
    fclk = 0; step(1);
    wr(23'h000002, 16'h0060);
    oe_n = 0; adv_n = 1; step(1);
    adv_n = 0; addr = 23'h03_00A0; step(1);
    fedge_pulse(1);
    adv_n = 1; addr = 23'h55_5555; step(1);
    chk("R13 sync op", op, 3);
    chk("R7 capture on clk", dq_out, arr(23'h03_00A0));
    fedge_pulse(0);
    chk("R9 no count on fall", dq_out, arr(23'h03_00A0));
    fedge_pulse(1);
    chk("R9 advance", dq_out, arr(23'h03_00A1));
    fedge_pulse(0); fedge_pulse(1);
    chk("R9 advance2", dq_out, arr(23'h03_00A2));
  endtask

  task automatic t_sync_adv();
    adv_n = 0; addr = 23'h10_0400; step(1);
    adv_n = 1; addr = 23'h00_0000; step(1);
    chk("R8 capture on adv rise", dq_out, arr(23'h10_0400));
    fedge_pulse(0); fedge_pulse(1);
    chk("R8 then advance", dq_out, arr(23'h10_0401));
  endtask

  task automatic t_wait_suspend();
    fedge_pulse(0);
    adv_n = 0; addr = 23'h00_003E; step(1);
    fedge_pulse(1);
    adv_n = 1; step(1);
    chk("R11 no wait mid row", wt, 0);
    fedge_pulse(0); fedge_pulse(1);
    chk("R9 at 3F", dq_out, arr(23'h00_003F));
    chk("R11 no wait 3F", wt, 0);
    fedge_pulse(0); fedge_pulse(1);
    chk("R11 wait at boundary", wt, 1);
    chk("R9 at 40", dq_out, arr(23'h00_0040));
    fedge_pulse(0);
    chk("R11 wait held in period", wt, 1);
    fedge_pulse(1);
    chk("R11 wait one period", wt, 0);
    oe_n = 1; step(4);
    chk("R10 suspend op", op, 4);
    chk("R10 suspend undriven", dq_oe, 0);
    oe_n = 0; step(1);
    chk("R10 same word", dq_out, arr(23'h00_0041));
    fedge_pulse(0); fedge_pulse(1);
    chk("R10 resume", dq_out, arr(23'h00_0042));
  endtask

  task automatic t_fall_edge();
    fclk = 1; step(1);
    wr(23'h000003, 16'h0060);
    oe_n = 0; adv_n = 1; step(1);
    adv_n = 0; addr = 23'h04_1000; step(1);
    fedge_pulse(0);
    adv_n = 1; addr = 23'h00_0000; step(1);
    chk("R13 falling capture", dq_out, arr(23'h04_1000));
    fedge_pulse(1);
    chk("R9 rising ignored", dq_out, arr(23'h04_1000));
    fedge_pulse(0);
    chk("R9 falling advance", dq_out, arr(23'h04_1001));
    oe_n = 1; step(1);
  endtask

  task automatic t_partition();
    wr(23'h0C_0000, 16'h0090);
    oe_n = 0; adv_n = 0; addr = 23'h0C_0000; step(1);
    chk("R12 id mfr", dq_out, 16'h00B7);
    addr = 23'h0C_0001; step(1);
    chk("R12 id dev", dq_out, 16'h88C1);
    addr = 23'h0C_0005; step(1);
    chk("R12 id other", dq_out, 16'h0000);
    addr = 23'h10_0000; step(1);
    chk("R12 other partition array", dq_out, arr(23'h10_0000));
    oe_n = 1;
    wr(23'h0C_0000, 16'h00FF);
    oe_n = 0; addr = 23'h0C_0001; step(1);
    chk("R12 back to array", dq_out, arr(23'h0C_0001));
    oe_n = 1;
    wr(23'h0C_0000, 16'h0090);
  endtask

  task automatic t_reset_state();
    t_reset();
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 23'h0C_0001; step(1);
    chk("R1 partitions array", dq_out, arr(23'h0C_0001));
    chk("R1 async mode", op, 2);
    fedge_pulse(1); fedge_pulse(0);
    chk("R1 clock ignored", dq_out, arr(23'h0C_0001));
  endtask

  initial begin
    step(2);
    #1;
    chk("R1 reset op", op, 0);
    chk("R1 reset hiz", {dq_oe, wt_oe}, 2'b00);
    rst_n = 1; step(1);
    t_standby_dir();
    t_async();
    t_sync_clk();
    t_sync_adv();
    t_wait_suspend();
    t_reset();
    t_fall_edge();
    t_reset();
    t_partition();
    t_reset_state();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule